// File: doc/BRIEF.md
# Two-Level Strided Address Generator

This block produces the byte address of every word in a nested transfer. A row holds a fixed number of words, and the transfer repeats that row a fixed number of times. Inside a row the address moves by a signed inner stride. When a row ends, a separate signed outer stride is applied in place of the inner stride. Because the outer stride can be negative, an interleaved multi-channel sample stream can be scattered into per-channel arrays, and the same arrays can be gathered back into a stream.

A data path loads the configuration with a one-cycle start pulse. It then takes words at its own pace, raising an advance strobe for each word it consumes. The block reports which address is current and whether that word closes a row. After the last word is taken it pulses done, and it also pulses an interrupt request if that was enabled at start. Words are 32 bits wide.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `valid_o`, `row_end_o`, `done_o` and `irq_o` are 0 and `addr_o` is 0.
- R2: A start pulse while idle captures the configuration. From the next cycle `valid_o` is 1 and `addr_o` equals the start address.
- R3: An accepted word that is not the last of its row moves the address by the inner stride. The stride is a 16-bit two's complement value sign-extended to 32 bits, so it may be negative.
- R4: `row_end_o` is 1 exactly while the current word is the last of its row. When that word is accepted, the address moves by the sign-extended outer stride instead of the inner stride.
- R5: A transfer delivers inner-count words per row and outer-count rows, for inner-count × outer-count words in total.
- R6: An inner or outer count of 0 behaves exactly like a count of 1.
- R7: A word is accepted only on a cycle where `advance_i` and `valid_o` are both 1. On any other cycle the address and the counters hold.
- R8: When the last word of the last row is accepted, `valid_o` is 0 on the next cycle and `done_o` is 1 for exactly that one cycle.
- R9: `irq_o` pulses in the same cycle as `done_o` only if `irq_en_i` was 1 at start. It is never raised at any other point of the transfer.
- R10: A start pulse while `valid_o` is 1 has no effect on the transfer in progress.
- R11: The configuration inputs are sampled only at an accepted start. Changing them during a transfer has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, loads the configuration |
| base_addr_i | input | 32 | Start byte address |
| inner_cnt_i | input | 16 | Words per row (0 acts as 1) |
| inner_stride_i | input | 16 | Signed byte step within a row |
| outer_cnt_i | input | 16 | Number of rows (0 acts as 1) |
| outer_stride_i | input | 16 | Signed byte step applied after a row's last word |
| irq_en_i | input | 1 | Request an interrupt at the end of the transfer |
| advance_i | input | 1 | Data path consumed the current word |
| addr_o | output | 32 | Current byte address |
| valid_o | output | 1 | A transfer is in progress and `addr_o` is meaningful |
| row_end_o | output | 1 | Current word is the last of its row |
| done_o | output | 1 | One-cycle pulse after the final word |
| irq_o | output | 1 | One-cycle interrupt request at completion |

## Verification
The main case is de-interleaving 4 channels with a block of 16. Every one of the 64 addresses is compared with the closed form base + channel×64 + frame×4. A design that added the outer stride on top of the inner stride would land 64 bytes too far at every row boundary. A design that zero-extended the stride would jump forward by nearly 64 KiB instead of stepping back. Zero counts are tested separately: a generator that wrapped the count would emit 65536 words instead of one. Gaps in the advance strobe must freeze the address. A start pulse and changed configuration inputs in the middle of a transfer must leave the sequence untouched. Finally, a transfer with interrupts disabled must complete with done but never with `irq_o`.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  localparam int unsigned ADDR_W_DEF   = 32;
  localparam int unsigned CNT_W_DEF    = 16;
  localparam int unsigned STRIDE_W_DEF = 16;

  // What the address accumulator does in a given cycle
  typedef enum logic [1:0] {
    STEP_HOLD  = 2'd0,
    STEP_INNER = 2'd1,
    STEP_OUTER = 2'd2
  } step_e;
endpackage

// File: rtl/dma2d_loop_ctr.sv
// Down counter for one loop level; reloads its limit when it wraps.
module dma2d_loop_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             step_i,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic [CNT_W-1:0] lim_eff;

  assign lim_eff = (limit_i == '0) ? ONE : limit_i;
  assign last_o  = (cnt_q == ONE);

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    if (load_i) begin
      cnt_d = lim_eff;
      lim_d = lim_eff;
    end else if (step_i) begin
      cnt_d = last_o ? lim_q : (cnt_q - ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ONE;
      lim_q <= ONE;
    end else if (load_i || step_i) begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end
endmodule

// File: rtl/dma2d_addr_acc.sv
// Address register with captured signed strides.
module dma2d_addr_acc
  import dma2d_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned STRIDE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [ADDR_W-1:0]   base_i,
  input  logic [STRIDE_W-1:0] inner_stride_i,
  input  logic [STRIDE_W-1:0] outer_stride_i,
  input  step_e               step_i,
  output logic [ADDR_W-1:0]   addr_o
);
  localparam int unsigned EXT_W = ADDR_W - STRIDE_W;

  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [STRIDE_W-1:0] xs_q, ys_q;
  logic [ADDR_W-1:0]   xs_ext, ys_ext;

  assign xs_ext = {{EXT_W{xs_q[STRIDE_W-1]}}, xs_q};
  assign ys_ext = {{EXT_W{ys_q[STRIDE_W-1]}}, ys_q};
  assign addr_o = addr_q;

  always_comb begin
    addr_d = addr_q;
    if (load_i) begin
      addr_d = base_i;
    end else begin
      unique case (step_i)
        STEP_INNER: addr_d = addr_q + xs_ext;
        STEP_OUTER: addr_d = addr_q + ys_ext;
        default:    addr_d = addr_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load_i || (step_i != STEP_HOLD)) begin
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xs_q <= '0;
      ys_q <= '0;
    end else if (load_i) begin
      xs_q <= inner_stride_i;
      ys_q <= outer_stride_i;
    end
  end
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int unsigned ADDR_W   = ADDR_W_DEF,
  parameter int unsigned CNT_W    = CNT_W_DEF,
  parameter int unsigned STRIDE_W = STRIDE_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [ADDR_W-1:0]   base_addr_i,
  input  logic [CNT_W-1:0]    inner_cnt_i,
  input  logic [STRIDE_W-1:0] inner_stride_i,
  input  logic [CNT_W-1:0]    outer_cnt_i,
  input  logic [STRIDE_W-1:0] outer_stride_i,
  input  logic                irq_en_i,
  input  logic                advance_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic                valid_o,
  output logic                row_end_o,
  output logic                done_o,
  output logic                irq_o
);
  logic  busy_q, busy_d;
  logic  done_q, done_d;
  logic  irq_q, irq_d;
  logic  irq_en_q;
  logic  load, take, inner_last, outer_last, final_word;
  step_e step;

  assign load       = start_i && !busy_q;
  assign take       = advance_i && busy_q;
  assign final_word = take && inner_last && outer_last;

  always_comb begin
    if (!take)           step = STEP_HOLD;
    else if (inner_last) step = STEP_OUTER;
    else                 step = STEP_INNER;
  end

  dma2d_loop_ctr #(.CNT_W(CNT_W)) u_inner (
    .clk(clk), .rst_n(rst_n), .load_i(load), .limit_i(inner_cnt_i),
    .step_i(take), .last_o(inner_last)
  );

  dma2d_loop_ctr #(.CNT_W(CNT_W)) u_outer (
    .clk(clk), .rst_n(rst_n), .load_i(load), .limit_i(outer_cnt_i),
    .step_i(take && inner_last), .last_o(outer_last)
  );

  dma2d_addr_acc #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .load_i(load), .base_i(base_addr_i),
    .inner_stride_i(inner_stride_i), .outer_stride_i(outer_stride_i),
    .step_i(step), .addr_o(addr_o)
  );

  always_comb begin
    busy_d = busy_q;
    if (load)            busy_d = 1'b1;
    else if (final_word) busy_d = 1'b0;
    done_d = final_word;
    irq_d  = final_word && irq_en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      irq_q  <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    irq_en_q <= 1'b0;
    else if (load) irq_en_q <= irq_en_i;
  end

  assign valid_o   = busy_q;
  assign row_end_o = busy_q && inner_last;
  assign done_o    = done_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              advance_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              valid_o,
  input logic              row_end_o,
  input logic              done_o,
  input logic              irq_o
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid_o) |-> done_o);

  // R9
  irq_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> done_o);

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !advance_i) |=> ($stable(addr_o) && valid_o));

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && start_i && !advance_i) |=> $stable(addr_o));

  // R4
  row_end_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_end_o |-> valid_o);
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .advance_i(advance_i),
  .addr_o(addr_o), .valid_o(valid_o), .row_end_o(row_end_o),
  .done_o(done_o), .irq_o(irq_o)
);

// File: tb/dma2d_addr_gen_tb.sv
module dma2d_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_addr_i = '0;
  logic [15:0] inner_cnt_i = '0;
  logic [15:0] inner_stride_i = '0;
  logic [15:0] outer_cnt_i = '0;
  logic [15:0] outer_stride_i = '0;
  logic        irq_en_i = 1'b0;
  logic        advance_i = 1'b0;
  logic [31:0] addr_o;
  logic        valid_o, row_end_o, done_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma2d_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
    .inner_cnt_i(inner_cnt_i), .inner_stride_i(inner_stride_i),
    .outer_cnt_i(outer_cnt_i), .outer_stride_i(outer_stride_i),
    .irq_en_i(irq_en_i), .advance_i(advance_i), .addr_o(addr_o),
    .valid_o(valid_o), .row_end_o(row_end_o), .done_o(done_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [15:0] s);
    return {{16{s[15]}}, s};
  endfunction

  // Drives a start pulse while idle; returns at the next negedge.
  task automatic begin_xfer(input logic [31:0] base, input logic [15:0] xc,
                            input logic [15:0] xm, input logic [15:0] yc,
                            input logic [15:0] ym, input logic ien);
    base_addr_i = base; inner_cnt_i = xc; inner_stride_i = xm;
    outer_cnt_i = yc; outer_stride_i = ym; irq_en_i = ien; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2", "valid after start", 32'(valid_o), 32'd1);
    chk("R2", "first address", addr_o, base);
  endtask

  // Walks a whole transfer; gap_every>0 inserts idle cycles.
  task automatic walk(input string req, input logic [31:0] base,
                      input logic [15:0] xc, input logic [15:0] xm,
                      input logic [15:0] yc, input logic [15:0] ym,
                      input logic ien, input int gap_every);
    int xe, ye, w;
    logic [31:0] exp;
    xe = (xc == 0) ? 1 : int'(xc);
    ye = (yc == 0) ? 1 : int'(yc);
    exp = base; w = 0;
    for (int r = 0; r < ye; r++) begin
      for (int c = 0; c < xe; c++) begin
        if (gap_every > 0 && (w % gap_every) == 1) begin
          advance_i = 1'b0;
          @(negedge clk);
          @(negedge clk);
          chk("R7", "address held without advance", addr_o, exp);
        end
        chk(req, "address", addr_o, exp);
        chk("R4", "row end flag", 32'(row_end_o), 32'(c == xe - 1));
        chk("R5", "valid during transfer", 32'(valid_o), 32'd1);
        chk("R9", "no irq mid transfer", 32'(irq_o), 32'd0);
        advance_i = 1'b1;
        @(negedge clk);
        advance_i = 1'b0;
        exp = exp + ((c == xe - 1) ? sx(ym) : sx(xm));
        w++;
      end
    end
    chk("R8", "valid low after final", 32'(valid_o), 32'd0);
    chk("R8", "done pulse", 32'(done_o), 32'd1);
    chk("R9", "irq at done", 32'(irq_o), 32'(ien));
    @(negedge clk);
    chk("R8", "done one cycle only", 32'(done_o), 32'd0);
    chk("R9", "irq one cycle only", 32'(irq_o), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1", "valid", 32'(valid_o), 32'd0);
    chk("R1", "row_end", 32'(row_end_o), 32'd0);
    chk("R1", "done", 32'(done_o), 32'd0);
    chk("R1", "irq", 32'(irq_o), 32'd0);
    chk("R1", "addr", addr_o, 32'd0);
  endtask

  // 4 channels x 16 frames of 4-byte words, scatter into channel arrays
  task automatic t_deinterleave();
    logic [15:0] ym;
    ym = 16'(((1 - 4) * 16 + 1) * 4);
    begin_xfer(32'h1000, 16'd4, 16'd64, 16'd16, ym, 1'b1);
    for (int i = 0; i < 64; i++) begin
      chk("R4", "closed form address", addr_o,
          32'h1000 + 32'((i % 4) * 64 + (i / 4) * 4));
      advance_i = 1'b1;
      @(negedge clk);
      advance_i = 1'b0;
    end
    chk("R5", "ends after 64 words", 32'(valid_o), 32'd0);
    chk("R9", "irq enabled", 32'(irq_o), 32'd1);
    @(negedge clk);
    begin_xfer(32'h2000, 16'd4, 16'd64, 16'd16, ym, 1'b1);
    walk("R4", 32'h2000, 16'd4, 16'd64, 16'd16, ym, 1'b1, 0);
  endtask

  task automatic t_gaps_no_irq();
    begin_xfer(32'h0000_0100, 16'd3, 16'd8, 16'd2, 16'd32, 1'b0);
    walk("R7", 32'h0000_0100, 16'd3, 16'd8, 16'd2, 16'd32, 1'b0, 2);
  endtask

  task automatic t_zero_counts();
    begin_xfer(32'h0000_4000, 16'd0, 16'd4, 16'd0, 16'd4, 1'b1);
    walk("R6", 32'h0000_4000, 16'd0, 16'd4, 16'd0, 16'd4, 1'b1, 0);
    begin_xfer(32'h0000_5000, 16'd3, 16'd4, 16'd0, 16'd4, 1'b0);
    walk("R6", 32'h0000_5000, 16'd3, 16'd4, 16'd0, 16'd4, 1'b0, 0);
  endtask

  task automatic t_negative_inner();
    begin_xfer(32'h0000_8000, 16'd3, 16'hFFF8, 16'd3, 16'd100, 1'b0);
    walk("R3", 32'h0000_8000, 16'd3, 16'hFFF8, 16'd3, 16'd100, 1'b0, 0);
  endtask

  task automatic t_restart_busy();
    begin_xfer(32'h0000_9000, 16'd2, 16'd4, 16'd2, 16'd16, 1'b1);
    advance_i = 1'b1;
    @(negedge clk);
    advance_i = 1'b0;
    chk("R3", "second word", addr_o, 32'h0000_9004);
    // R10 / R11: new start and new config mid-transfer
    base_addr_i = 32'hDEAD_0000; inner_cnt_i = 16'd9; inner_stride_i = 16'd1;
    outer_cnt_i = 16'd9; outer_stride_i = 16'd1; irq_en_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R10", "start while busy ignored", addr_o, 32'h0000_9004);
    chk("R11", "row end unchanged", 32'(row_end_o), 32'd1);
    advance_i = 1'b1;
    @(negedge clk);
    chk("R11", "old outer stride used", addr_o, 32'h0000_9014);
    @(negedge clk);
    chk("R11", "old inner stride used", addr_o, 32'h0000_9018);
    @(negedge clk);
    advance_i = 1'b0;
    chk("R11", "old counts end transfer", 32'(done_o), 32'd1);
    chk("R11", "old irq enable kept", 32'(irq_o), 32'd1);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_deinterleave();
    t_gaps_no_irq();
    t_zero_counts();
    t_negative_inner();
    t_restart_busy();
    finished = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end
endmodule